// File: doc/BRIEF.md
# Configurable TDM Audio Serial Transmitter

This block is the transmit side of a master-mode serial audio port. From the system clock it produces a bit clock and a frame clock. It shifts out one stereo pair of signed samples in every frame. The framing is chosen at run time and covers I2S, left-justified, right-justified and longer TDM-style frames. The frame length, the order of the two channels within the pair, the bit order and the delay of the first data bit after the frame clock edge all come from plain configuration inputs. The block takes those inputs only at a frame boundary.

Sample pairs arrive on a valid/ready stream and wait in a one-entry holding register. That register is emptied into the shifter at the start of each frame. Back-pressure is simple: `in_ready` is low for as long as a pair is waiting, so a source that runs faster than the frame rate stalls until the next frame begins. A source that falls behind is not stalled. Instead the previous pair is sent again and a one-cycle `underrun` pulse marks the repeated frame. A configuration that cannot fit in its half-frame, or a reserved frame code, raises `config_error` and mutes the data line for that frame.

Top module: `tdm_serial_tx`

## Requirements
- R1: `cfg_frame_code` selects the number of bit clocks per frame: 0=64, 1=32, 2=48, 3=128, 4=256. Codes 5, 6 and 7 are reserved; they run 64-clock frames with `config_error` set.
- R2: `bclk` has a period of 2*DIV_HALF system clocks. `lrclk` is low for the first half of each frame and high for the second half. Each half-frame is one channel slot.
- R3: `cfg_delay_code` sets the number of bit clocks from the start of a slot to its first data bit: 0 gives 1 (I2S), 1 gives 0 (left-justified), 2 gives 8, and 3 gives 16.
- R4: `cfg_lsb_first`=0 sends each sample MSB first. A value of 1 sends it LSB first.
- R5: `cfg_swap`=0 sends the left sample in the first slot and the right sample in the second. A value of 1 sends the right sample first.
- R6: `cfg_wide`=1 sends all 24 bits of each sample. A value of 0 sends bits [15:0]. Every bit position in a slot that carries no sample bit drives 0.
- R7: `config_error` is 1 for a whole frame when that frame uses a reserved code, or when delay plus sample width exceeds half the frame length. While it is 1, `sdata` is 0. Two examples: 24-bit samples with delay 16 in a 64-clock frame are flagged, and 16-bit samples with the same delay and frame are not.
- R8: `sdata` and `lrclk` change only in the cycle where `bclk` falls, so a receiver samples them on the rising edge.
- R9: The configuration inputs are captured at the frame boundary. A change made during a frame does not alter that frame's length or data, and it takes effect from the next frame.
- R10: A pair is accepted when `in_valid` and `in_ready` are both 1. `in_ready` is then 0 until the next frame starts, and that frame sends the accepted pair.
- R11: If no pair is waiting when a frame starts, the previous pair is sent again and `underrun` is 1 for exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame_code | input | 3 | Frame length code |
| cfg_swap | input | 1 | Channel order within the pair |
| cfg_lsb_first | input | 1 | Bit order |
| cfg_delay_code | input | 2 | First-bit delay code |
| cfg_wide | input | 1 | 1 selects 24-bit samples, 0 selects 16-bit samples |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Holding register empty |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| sdata | output | 1 | Serial data |
| config_error | output | 1 | Active frame has an invalid setting |
| underrun | output | 1 | One-cycle pulse when a frame repeats the previous pair |

## Verification
The checker watches the timing rules on every cycle. These are: data and frame clock move only with a falling bit clock, a flagged frame stays silent, the error flag moves only at a frame edge, underrun is a single-cycle pulse, and an accepted pair closes the ready signal. The slot contents cannot be shown by a per-cycle property and need the bench's frame-by-frame comparison. That comparison covers each frame length, each delay code, the bit and channel orders, both sample widths, invalid combinations, configuration changes made mid-frame and repeated pairs.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef struct packed {
    logic [2:0] frame_code;
    logic       swap;
    logic       lsb_first;
    logic [1:0] delay_code;
    logic       wide;
  } tdm_cfg_t;

  localparam int POS_W = 9;

  function automatic logic [POS_W-1:0] frame_len(input logic [2:0] code);
    case (code)
      3'd0:    frame_len = 9'd64;
      3'd1:    frame_len = 9'd32;
      3'd2:    frame_len = 9'd48;
      3'd3:    frame_len = 9'd128;
      3'd4:    frame_len = 9'd256;
      default: frame_len = 9'd64;
    endcase
  endfunction

  function automatic logic code_reserved(input logic [2:0] code);
    code_reserved = (code > 3'd4);
  endfunction

  function automatic logic [4:0] first_bit_delay(input logic [1:0] code);
    case (code)
      2'd0:    first_bit_delay = 5'd1;
      2'd1:    first_bit_delay = 5'd0;
      2'd2:    first_bit_delay = 5'd8;
      default: first_bit_delay = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = (cnt == LAST);
  assign fall_tick = tick && bclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
  import tdm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_tick,
  input  tdm_cfg_t         cfg_in,
  output logic             run,
  output logic [POS_W-1:0] pos,
  output tdm_cfg_t         cfg_act,
  output logic             err,
  output logic             frame_start
);
  localparam int EW = POS_W + 1;

  logic [POS_W-1:0] len_act;
  logic [EW-1:0]    need_in;
  logic [EW-1:0]    half_in;
  logic             bad_in;

  assign len_act     = frame_len(cfg_act.frame_code);
  assign frame_start = fall_tick && (!run || (pos == len_act - 1'b1));

  assign need_in = EW'(first_bit_delay(cfg_in.delay_code)) +
                   (cfg_in.wide ? EW'(SAMPLE_W) : EW'(NARROW_W));
  assign half_in = EW'(frame_len(cfg_in.frame_code) >> 1);
  assign bad_in  = code_reserved(cfg_in.frame_code) || (need_in > half_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      pos     <= '0;
      cfg_act <= '0;
      err     <= 1'b0;
    end else if (frame_start) begin
      run     <= 1'b1;
      pos     <= '0;
      cfg_act <= cfg_in;
      err     <= bad_in;
    end else if (fall_tick) begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_pair_buf.sv
module tdm_pair_buf #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic [SAMPLE_W-1:0] act_left,
  output logic [SAMPLE_W-1:0] act_right,
  output logic                underrun
);
  logic                pend;
  logic [SAMPLE_W-1:0] hold_l;
  logic [SAMPLE_W-1:0] hold_r;
  logic                take;

  assign in_ready = !pend;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      act_left  <= '0;
      act_right <= '0;
      underrun  <= 1'b0;
    end else begin
      underrun <= frame_start && !pend;
      if (take) begin
        pend   <= 1'b1;
        hold_l <= in_left;
        hold_r <= in_right;
      end else if (frame_start && pend) begin
        pend      <= 1'b0;
        act_left  <= hold_l;
        act_right <= hold_r;
      end
    end
  end
endmodule

// File: rtl/tdm_bit_pick.sv
module tdm_bit_pick
  import tdm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16
) (
  input  logic                run,
  input  logic [POS_W-1:0]    pos,
  input  tdm_cfg_t            cfg_act,
  input  logic                err,
  input  logic [SAMPLE_W-1:0] act_left,
  input  logic [SAMPLE_W-1:0] act_right,
  output logic                sdata,
  output logic                lrclk
);
  localparam int IW = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  logic [POS_W-1:0]    half;
  logic                second;
  logic [POS_W-1:0]    slot_pos;
  logic [POS_W-1:0]    dly;
  logic [POS_W-1:0]    width;
  logic [POS_W-1:0]    k;
  logic [POS_W-1:0]    idx;
  logic                in_win;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    half     = frame_len(cfg_act.frame_code) >> 1;
    second   = (pos >= half);
    slot_pos = second ? (pos - half) : pos;
    dly      = POS_W'(first_bit_delay(cfg_act.delay_code));
    width    = cfg_act.wide ? POS_W'(SAMPLE_W) : POS_W'(NARROW_W);
    k        = slot_pos - dly;
    in_win   = (slot_pos >= dly) && (k < width);
    idx      = cfg_act.lsb_first ? k : (width - 1'b1 - k);
    word     = (second ^ cfg_act.swap) ? act_right : act_left;
    lrclk    = run && second;
    sdata    = run && !err && in_win && word[idx[IW-1:0]];
  end
endmodule

// File: rtl/tdm_serial_tx.sv
module tdm_serial_tx
  import tdm_tx_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_frame_code,
  input  logic                cfg_swap,
  input  logic                cfg_lsb_first,
  input  logic [1:0]          cfg_delay_code,
  input  logic                cfg_wide,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                config_error,
  output logic                underrun
);
  tdm_cfg_t         cfg_in;
  tdm_cfg_t         cfg_act;
  logic             fall_tick;
  logic             run;
  logic [POS_W-1:0] pos;
  logic             frame_start;
  logic [SAMPLE_W-1:0] act_left;
  logic [SAMPLE_W-1:0] act_right;

  assign cfg_in = '{frame_code: cfg_frame_code, swap: cfg_swap,
                    lsb_first: cfg_lsb_first, delay_code: cfg_delay_code,
                    wide: cfg_wide};

  tdm_bclk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fall_tick(fall_tick)
  );

  tdm_frame_ctl #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .cfg_in(cfg_in),
    .run(run), .pos(pos), .cfg_act(cfg_act), .err(config_error),
    .frame_start(frame_start)
  );

  tdm_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .act_left(act_left), .act_right(act_right), .underrun(underrun)
  );

  tdm_bit_pick #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_pick (
    .run(run), .pos(pos), .cfg_act(cfg_act), .err(config_error),
    .act_left(act_left), .act_right(act_right),
    .sdata(sdata), .lrclk(lrclk)
  );
endmodule

// File: rtl/tdm_serial_tx_chk.sv
module tdm_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic lrclk,
  input logic sdata,
  input logic config_error,
  input logic underrun,
  input logic in_valid,
  input logic in_ready
);
  AST_MUTE_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !sdata); // R7

  AST_SDATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata != $past(sdata)) |-> ($past(bclk) && !bclk)); // R8

  AST_LRCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lrclk != $past(lrclk)) |-> ($past(bclk) && !bclk)); // R8

  AST_ERR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (config_error != $past(config_error)) |-> ($past(bclk) && !bclk && !lrclk)); // R9

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R11

  AST_READY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R10
endmodule

bind tdm_serial_tx tdm_serial_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
  .config_error(config_error), .underrun(underrun),
  .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/tdm_serial_tx_tb_top.sv
module tdm_serial_tx_tb_top;
  localparam int DIV_HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  cfg_frame_code = 3'd0;
  logic        cfg_swap = 1'b0, cfg_lsb_first = 1'b0, cfg_wide = 1'b1;
  logic [1:0]  cfg_delay_code = 2'd0;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic        in_ready, bclk, lrclk, sdata, config_error, underrun;

  tdm_serial_tx #(.DIV_HALF(DIV_HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_frame_code(cfg_frame_code),
    .cfg_swap(cfg_swap), .cfg_lsb_first(cfg_lsb_first),
    .cfg_delay_code(cfg_delay_code), .cfg_wide(cfg_wide),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
    .in_right(in_right), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .config_error(config_error), .underrun(underrun)
  );

  typedef struct {
    int          code;
    bit          swap;
    bit          lsb;
    int          dcode;
    bit          wide;
    logic [23:0] l;
    logic [23:0] r;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  event ev_rise, ev_fs;
  logic s_sd = 0, s_lr = 0, s_err = 0, s_fs = 0;
  logic prev_b = 0, prev_lr = 0, last_sd = 0, last_lr = 0;
  int   r8_bad = 0, und_cnt = 0, rise_cnt = 0, last_frame_len = 0;
  int   cyc = 0, last_rise_cyc = 0, bclk_period = 0;
  bit   mon_busy = 0;
  bit   done = 0;

  function automatic int flen_of(int code);
    case (code)
      0: return 64;  1: return 32;  2: return 48;
      3: return 128; 4: return 256; default: return 64;
    endcase
  endfunction

  function automatic int dly_of(int dcode);
    case (dcode)
      0: return 1; 1: return 0; 2: return 8; default: return 16;
    endcase
  endfunction

  function automatic bit err_of(exp_t e);
    int w = e.wide ? 24 : 16;
    return (e.code > 4) || (dly_of(e.dcode) + w > flen_of(e.code) / 2);
  endfunction

  function automatic logic bit_of(exp_t e, int p);
    int half = flen_of(e.code) / 2;
    int w = e.wide ? 24 : 16;
    int d = dly_of(e.dcode);
    bit sec = (p >= half);
    int b = sec ? p - half : p;
    logic [23:0] s;
    if (err_of(e)) return 1'b0;
    if (b < d || b >= d + w) return 1'b0;
    s = (sec ^ e.swap) ? e.r : e.l;
    return e.lsb ? s[b - d] : s[w - 1 - (b - d)];
  endfunction

  task automatic check(input bit ok, input string req, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, msg, act, expv);
    end
  endtask

  // sampler
  always begin
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      if (underrun) und_cnt++;
      if (((sdata !== last_sd) || (lrclk !== last_lr)) && !(prev_b && !bclk)) r8_bad++;
      if (bclk && !prev_b) begin
        s_sd  = sdata;
        s_lr  = lrclk;
        s_err = config_error;
        s_fs  = prev_lr && !lrclk;
        prev_lr = lrclk;
        if (last_rise_cyc != 0) bclk_period = cyc - last_rise_cyc;
        last_rise_cyc = cyc;
        if (s_fs) begin last_frame_len = rise_cnt; rise_cnt = 1; end
        else rise_cnt++;
        ->ev_rise;
        if (s_fs) ->ev_fs;
      end
    end
    prev_b  = bclk;
    last_sd = sdata;
    last_lr = lrclk;
  end

  // monitor: pops one expected frame per frame start and compares bits
  initial begin
    forever begin
      exp_t it;
      int flen, bad, ebad, bad_p;
      logic act_b, exp_b;
      wait (q.size() > 0);
      @(ev_fs);
      it = q.pop_front();
      mon_busy = 1;
      flen = flen_of(it.code);
      bad = 0; ebad = 0; bad_p = 0; act_b = 0; exp_b = 0;
      for (int p = 0; p < flen; p++) begin
        if (p > 0) @(ev_rise);
        if (s_sd !== bit_of(it, p) || s_lr !== (p >= flen / 2)) begin
          if (bad == 0) begin bad_p = p; act_b = s_sd; exp_b = bit_of(it, p); end
          bad++;
        end
        if (s_err !== err_of(it)) ebad++;
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL %s frame bits: first mismatch at pos %0d actual=%0b expected=%0b (%0d bad)",
                 it.tag, bad_p, act_b, exp_b, bad);
      end
      check(ebad == 0, "R7", {it.tag, " config_error"}, s_err, err_of(it));
      mon_busy = 0;
    end
  end

  int cur_len = 64;
  logic [23:0] last_l = '0, last_r = '0;

  task automatic run_frame(input int code, input bit swap, input bit lsb, input int dcode,
                           input bit wide, input logic [23:0] l, input logic [23:0] r,
                           input bit give, input string tag);
    exp_t e;
    int u0;
    @(ev_fs);
    check(in_ready === 1'b1, "R10", "ready open after frame start", in_ready, 1);
    cfg_frame_code = code[2:0]; cfg_swap = swap; cfg_lsb_first = lsb;
    cfg_delay_code = dcode[1:0]; cfg_wide = wide;
    if (give) begin
      in_left = l; in_right = r; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      check(in_ready === 1'b0, "R10", "ready closed while pair waits", in_ready, 0);
      in_valid = 1'b0;
      last_l = l; last_r = r;
    end
    e = '{code: code, swap: swap, lsb: lsb, dcode: dcode, wide: wide,
          l: last_l, r: last_r, tag: tag};
    q.push_back(e);
    u0 = und_cnt;
    @(ev_fs);
    check(last_frame_len == cur_len, "R9", "frame length during mid-frame change", last_frame_len, cur_len);
    check((und_cnt - u0) == (give ? 0 : 1), "R11", "underrun pulses at frame start", und_cnt - u0, give ? 0 : 1);
    cur_len = flen_of(code);
    wait (q.size() == 0);
    wait (!mon_busy);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R10", "reset in_ready", in_ready, 1);
    check(sdata === 1'b0 && lrclk === 1'b0 && bclk === 1'b0, "R2", "reset outputs idle",
          {sdata, lrclk, bclk}, 0);
    check(config_error === 1'b0 && underrun === 1'b0, "R7", "reset flags clear",
          {config_error, underrun}, 0);

    run_frame(0, 0, 0, 0, 1, 24'h9A3C71, 24'h1E58F2, 1, "R1 R3 I2S 64/24");
    check(bclk_period == 2 * DIV_HALF, "R2", "bclk period", bclk_period, 2 * DIV_HALF);
    run_frame(1, 0, 0, 1, 0, 24'h00C35A, 24'h0081E7, 1, "R1 R6 32/16 left-justified");
    run_frame(2, 0, 0, 1, 1, 24'hF00D17, 24'h2B6E90, 1, "R1 48/24");
    run_frame(0, 0, 0, 2, 1, 24'h800001, 24'h7FFFFE, 1, "R3 right-justified 64/24");
    run_frame(0, 1, 1, 0, 1, 24'hC0FFEE, 24'h13579B, 1, "R4 R5 lsb-first swapped");
    run_frame(3, 0, 0, 3, 0, 24'h00A5F3, 24'h005C81, 1, "R3 R6 128/16 delay16");
    run_frame(4, 1, 0, 0, 1, 24'h6D2E4A, 24'hB19307, 1, "R1 R5 256/24");
    run_frame(0, 0, 0, 3, 0, 24'h00ABCD, 24'h001234, 1, "R7 valid 64/16 delay16");
    run_frame(0, 0, 0, 3, 1, 24'hFFFFFF, 24'hFFFFFF, 1, "R7 invalid 64/24 delay16");
    run_frame(5, 0, 0, 0, 1, 24'hFFFFFF, 24'hFFFFFF, 1, "R1 R7 reserved code");
    run_frame(1, 0, 0, 0, 1, 24'hFFFFFF, 24'hFFFFFF, 1, "R7 invalid 32/24");
    run_frame(0, 0, 1, 1, 1, 24'h5A0F3C, 24'hA5F0C3, 1, "R9 R4 back to 64");
    run_frame(0, 0, 1, 1, 1, 24'h0, 24'h0, 0, "R11 repeated pair");

    check(r8_bad == 0, "R8", "sdata/lrclk change only with falling bclk", r8_bad, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule